// File: doc/BRIEF.md
# Digit-Serial Radix Converter

The converter moves numbers between binary and any radix from 2 to 16, one digit at a time, on a single iterative engine. A `start` pulse taken while the unit is idle latches the operation (`mode`), the radix, and, for the output modes, a binary operand on `value_in`. The operation then runs to completion; a `start` seen while the unit is busy is dropped.

- **Accumulate mode (0).** Digits stream in on a valid/ready channel, most significant first. They are folded into a `W`-bit binary result by multiply-by-radix-and-add. An option gives the leading digit negative weight, so a two's-complement bit string is read as a signed value.
- **Integer mode (1).** `value_in` is split into digits by repeated division by the radix. Each remainder is emitted as a digit, least significant first.
- **Fraction mode (2).** `value_in` is read as a fraction of `2^W`. Repeated multiplication by the radix emits the whole parts as digits, most significant first, for a programmed number of digits.

Both digit channels follow valid/ready rules. A transfer happens on a rising edge where valid and ready are both high.

- **Input side.** The sender may present a digit at any time. `in_ready` is high only while an accumulate operation is in progress.
- **Output side.** Once `out_valid` rises, it stays high with `out_digit` and `out_last` frozen until `out_ready` accepts the digit. The engine makes no progress while it waits.

`done` is a level that is set when an operation finishes and cleared by the next accepted start. `err` is a sticky flag, cleared by the next accepted start that has a valid configuration.

Top module: `radix_conv`

## Requirements
- R1: In mode 0 with `neg_lead` low, the result starts at 0 and each accepted digit d turns it into result*radix + d, modulo 2^W. The digit carrying `in_last` ends the operation: `done` goes high and `result` holds the value. Example: bits 1,0,1,1,0,1,0,1 in radix 2 give 181.
- R2: In mode 0 with `neg_lead` high, the first accepted digit d sets the result to -d (two's complement, W bits). Later digits follow R1. Example: the same bit string gives -75.
- R3: In mode 0, a digit with value >= radix is handled as follows:
  - it sets `err`, and `err` stays set until the next accepted valid start;
  - it changes neither the result nor the first-digit state;
  - if it carries `in_last`, that flag is ignored and the operation continues.
- R4: In mode 1, each step emits `value mod radix` as the next digit and continues with the quotient, least significant digit first. `out_last` marks the digit after which the quotient is zero. Example: 19 in radix 3 emits 1, 0, 2.
- R5: In mode 1, an operand of 0 emits exactly one digit, 0, with `out_last` high.
- R6: In mode 2, each step forms frac*radix. The bits above position W-1 are emitted as the digit, and the low W bits are kept. Exactly `frac_digits` digits are emitted, with `out_last` on the final one, even if the kept fraction is still nonzero. A count of 0 emits nothing and sets `done`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_digit` and `out_last` hold their values on the next cycle.
- R8: A start with radix outside 2..16, or with mode 3, sets `err` and `done` within the same edge, leaves the unit idle, and produces no digit traffic.
- R9: `busy` is high from an accepted start until the operation ends. `done` is never high while `busy` is high. A start while busy is ignored.
- R10: `in_ready` and `out_valid` are never high together. `in_ready` is high only during mode 0, and `out_valid` only during modes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 2 | 0 accumulate, 1 integer out, 2 fraction out, 3 invalid |
| radix | input | 5 | Radix, valid 2..16 |
| neg_lead | input | 1 | Mode 0: leading digit has negative weight |
| frac_digits | input | CW (5) | Mode 2: number of digits to emit |
| value_in | input | W (16) | Operand for modes 1 and 2 |
| in_valid | input | 1 | Input digit valid |
| in_ready | output | 1 | Input digit accepted when high with in_valid |
| in_digit | input | 4 | Input digit |
| in_last | input | 1 | Input digit is the final one |
| out_valid | output | 1 | Output digit valid |
| out_ready | input | 1 | Downstream accepts the output digit |
| out_digit | output | 4 | Output digit |
| out_last | output | 1 | Output digit is the final one |
| result | output | W (16) | Mode 0 result, meaningful once done |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation finished |
| err | output | 1 | Sticky error flag |

## Verification
The bench keeps a behavioural model of every operation: digit queues for the output modes and a Horner sum for accumulation. It compares every output handshake, and it checks the hold and exclusivity rules on every clock under random back-pressure.

The corner cases the bench targets, and what a faulty design would show on each:

- **Signed leading digit.** Mishandled, it yields 181 in place of -75.
- **Zero operand in integer mode.** A faulty design emits nothing and never finishes.
- **Fraction whose expansion does not end.** A wrong digit count shows as a missing or extra digit.
- **Power-of-two radices.** A faulty shortcut path gives wrong low-order digits.
- **Bad digit carrying the last flag.** A design that honours the flag ends early with a wrong result.
- **Start pulse during a stalled conversion.** A design that takes it corrupts the digit stream.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    MODE_HORNER = 2'd0,
    MODE_INT    = 2'd1,
    MODE_FRAC   = 2'd2,
    MODE_BAD    = 2'd3
  } rc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HORN = 2'd1,
    ST_STEP = 2'd2,
    ST_EMIT = 2'd3
  } rc_state_e;
endpackage

// File: rtl/rc_horner_step.sv
module rc_horner_step #(
  parameter int W  = 16,
  parameter int DW = 4,
  parameter int RW = DW + 1
) (
  input  logic [W-1:0]  acc,
  input  logic [DW-1:0] digit,
  input  logic [RW-1:0] radix,
  input  logic          negate,
  output logic [W-1:0]  acc_nxt
);
  logic [W-1:0] dig_ext, rad_ext;

  assign dig_ext = {{(W-DW){1'b0}}, digit};
  assign rad_ext = {{(W-RW){1'b0}}, radix};

  always_comb begin
    if (negate) acc_nxt = '0 - dig_ext;
    else        acc_nxt = acc * rad_ext + dig_ext;
  end
endmodule

// File: rtl/rc_div_step.sv
module rc_div_step #(
  parameter int W  = 16,
  parameter int DW = 4,
  parameter int RW = DW + 1
) (
  input  logic [DW-1:0] rem,
  input  logic [W-1:0]  quo,
  input  logic [RW-1:0] radix,
  output logic [DW-1:0] rem_nxt,
  output logic [W-1:0]  quo_nxt
);
  logic [RW-1:0] trial;
  logic          fits;
  logic [RW-1:0] diff;

  assign trial   = {rem, quo[W-1]};
  assign fits    = trial >= radix;
  assign diff    = trial - radix;
  assign rem_nxt = fits ? diff[DW-1:0] : trial[DW-1:0];
  assign quo_nxt = {quo[W-2:0], fits};
endmodule

// File: rtl/rc_pow2_split.sv
module rc_pow2_split #(
  parameter int W  = 16,
  parameter int DW = 4,
  parameter int RW = DW + 1
) (
  input  logic [W-1:0]  value,
  input  logic [RW-1:0] radix,
  output logic          hit,
  output logic [DW-1:0] digit,
  output logic [W-1:0]  quo
);
  localparam int SHW = $clog2(RW);
  logic [SHW-1:0] sh;
  logic [RW-1:0]  mask;

  always_comb begin
    sh = '0;
    for (int i = 0; i < RW; i++)
      if (radix[i]) sh = SHW'(i);
  end

  assign mask  = radix - RW'(1);
  assign hit   = (radix & mask) == '0;
  assign digit = value[DW-1:0] & mask[DW-1:0];
  assign quo   = value >> sh;
endmodule

// File: rtl/rc_frac_step.sv
module rc_frac_step #(
  parameter int W  = 16,
  parameter int DW = 4,
  parameter int RW = DW + 1
) (
  input  logic [W-1:0]  frac,
  input  logic [RW-1:0] radix,
  output logic [DW-1:0] digit,
  output logic [W-1:0]  frac_nxt
);
  localparam int PW = W + DW;
  logic [PW-1:0] prod;

  assign prod     = {{DW{1'b0}}, frac} * {{(PW-RW){1'b0}}, radix};
  assign digit    = prod[PW-1:W];
  assign frac_nxt = prod[W-1:0];
endmodule

// File: rtl/radix_conv.sv
module radix_conv
  import rc_pkg::*;
#(
  parameter int W         = 16,
  parameter int DW        = 4,
  parameter int CW        = 5,
  parameter bit FAST_POW2 = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [DW:0]   radix,
  input  logic          neg_lead,
  input  logic [CW-1:0] frac_digits,
  input  logic [W-1:0]  value_in,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_digit,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_digit,
  output logic          out_last,
  output logic [W-1:0]  result,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int RW   = DW + 1;
  localparam int MAXR = 1 << DW;
  localparam int SW   = $clog2(W);

  rc_state_e     st_q;
  rc_mode_e      mode_q, mode_e;
  logic [RW-1:0] rad_q;
  logic          neg_q, first_q;
  logic [W-1:0]  acc_q, quo_q, frac_q;
  logic [DW-1:0] rem_q, dig_q;
  logic [SW-1:0] step_q;
  logic [CW-1:0] left_q;
  logic          last_q, done_q, err_q;

  logic          cfg_ok, dig_bad, take_in, take_out;
  logic [W-1:0]  h_nxt, d_quo, f_nxt, p_quo;
  logic [DW-1:0] d_rem, f_dig, p_dig;
  logic          p_hit;

  assign mode_e   = rc_mode_e'(mode);
  assign cfg_ok   = (radix >= RW'(2)) && (radix <= RW'(MAXR)) && (mode_e != MODE_BAD);
  assign dig_bad  = {1'b0, in_digit} >= rad_q;
  assign in_ready = (st_q == ST_HORN);
  assign take_in  = in_ready && in_valid;
  assign out_valid = (st_q == ST_EMIT);
  assign take_out = out_valid && out_ready;
  assign out_digit = dig_q;
  assign out_last  = last_q;
  assign result    = acc_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;

  rc_horner_step #(.W(W), .DW(DW), .RW(RW)) u_horn (
    .acc(acc_q), .digit(in_digit), .radix(rad_q),
    .negate(first_q && neg_q), .acc_nxt(h_nxt)
  );

  rc_div_step #(.W(W), .DW(DW), .RW(RW)) u_div (
    .rem(rem_q), .quo(quo_q), .radix(rad_q),
    .rem_nxt(d_rem), .quo_nxt(d_quo)
  );

  rc_frac_step #(.W(W), .DW(DW), .RW(RW)) u_frac (
    .frac(frac_q), .radix(rad_q), .digit(f_dig), .frac_nxt(f_nxt)
  );

  generate
    if (FAST_POW2) begin : g_pow2
      rc_pow2_split #(.W(W), .DW(DW), .RW(RW)) u_p2 (
        .value(acc_q), .radix(rad_q), .hit(p_hit), .digit(p_dig), .quo(p_quo)
      );
    end else begin : g_nopow2
      assign p_hit = 1'b0;
      assign p_dig = '0;
      assign p_quo = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mode_q  <= MODE_HORNER;
      rad_q   <= RW'(2);
      neg_q   <= 1'b0;
      first_q <= 1'b0;
      acc_q   <= '0;
      quo_q   <= '0;
      frac_q  <= '0;
      rem_q   <= '0;
      dig_q   <= '0;
      step_q  <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            if (!cfg_ok) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              err_q  <= 1'b0;
              done_q <= 1'b0;
              rad_q  <= radix;
              mode_q <= mode_e;
              neg_q  <= neg_lead;
              case (mode_e)
                MODE_HORNER: begin
                  acc_q   <= '0;
                  first_q <= 1'b1;
                  st_q    <= ST_HORN;
                end
                MODE_INT: begin
                  acc_q  <= value_in;
                  quo_q  <= value_in;
                  rem_q  <= '0;
                  step_q <= '0;
                  st_q   <= ST_STEP;
                end
                default: begin
                  frac_q <= value_in;
                  left_q <= frac_digits;
                  if (frac_digits == '0) done_q <= 1'b1;
                  else                   st_q   <= ST_STEP;
                end
              endcase
            end
          end
        end
        ST_HORN: begin
          if (take_in) begin
            if (dig_bad) begin
              err_q <= 1'b1;
            end else begin
              acc_q   <= h_nxt;
              first_q <= 1'b0;
              if (in_last) begin
                done_q <= 1'b1;
                st_q   <= ST_IDLE;
              end
            end
          end
        end
        ST_STEP: begin
          if (mode_q == MODE_FRAC) begin
            dig_q  <= f_dig;
            frac_q <= f_nxt;
            last_q <= (left_q == CW'(1));
            st_q   <= ST_EMIT;
          end else if (p_hit) begin
            dig_q  <= p_dig;
            acc_q  <= p_quo;
            last_q <= (p_quo == '0);
            st_q   <= ST_EMIT;
          end else begin
            rem_q  <= d_rem;
            quo_q  <= d_quo;
            step_q <= step_q + SW'(1);
            if (step_q == SW'(W-1)) begin
              dig_q  <= d_rem;
              acc_q  <= d_quo;
              last_q <= (d_quo == '0);
              st_q   <= ST_EMIT;
            end
          end
        end
        default: begin
          if (take_out) begin
            if (last_q) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_STEP;
              if (mode_q == MODE_FRAC) begin
                left_q <= left_q - CW'(1);
              end else begin
                quo_q  <= acc_q;
                rem_q  <= '0;
                step_q <= '0;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rc_chk.sv
module rc_chk #(
  parameter int DW = 4,
  parameter int RW = DW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_digit,
  input logic          out_last,
  input logic [RW-1:0] rad_q
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_digit) && $stable(out_last));

  // R10
  chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R10
  in_ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> busy);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(start && !busy) |=> err);

  // R4
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({1'b0, out_digit} < rad_q));
endmodule

bind radix_conv rc_chk #(.DW(DW)) u_rc_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_digit(out_digit), .out_last(out_last),
  .rad_q(rad_q)
);

// File: tb/test_radix_conv.sv
module test_radix_conv;
  localparam int W = 16, DW = 4, CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = '0;
  logic [DW:0] radix = 5'd2;
  logic neg_lead = 1'b0;
  logic [CW-1:0] frac_digits = '0;
  logic [W-1:0] value_in = '0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [DW-1:0] in_digit = '0;
  logic in_ready, out_valid, out_last, busy, done, err;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_digit;
  logic [W-1:0] result;

  radix_conv #(.W(W), .DW(DW), .CW(CW)) i_radix_conv (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .radix(radix),
    .neg_lead(neg_lead), .frac_digits(frac_digits), .value_in(value_in),
    .in_valid(in_valid), .in_ready(in_ready), .in_digit(in_digit),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_digit(out_digit), .out_last(out_last), .result(result),
    .busy(busy), .done(done), .err(err)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int expq[$];
  string cur_req = "R4";
  int stall_mode = 0;
  logic [7:0] lfsr = 8'h5A;
  logic prev_stall = 1'b0;
  logic [DW-1:0] prev_dig = '0;
  logic prev_last = 1'b0;
  int hdig[32];
  bit hlast[32];
  int hn = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // back-pressure driver
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (stall_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] | lfsr[3];
      default: out_ready = 1'b0;
    endcase
  end

  // per-clock comparison against the model
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      chk(!(in_ready && out_valid), "R10", int'(in_ready), 0);
      if (prev_stall) begin
        chk(out_valid && out_digit == prev_dig && out_last == prev_last, "R7",
            int'(out_digit), int'(prev_dig));
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, cur_req, int'(out_digit), -1);
        end else begin
          chk(int'(out_digit) == expq[0], cur_req, int'(out_digit), expq[0]);
          chk(out_last == (expq.size() == 1), cur_req, int'(out_last), int'(expq.size() == 1));
          void'(expq.pop_front());
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_dig   = out_digit;
      prev_last  = out_last;
    end
  end

  // watchdog
  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    wrap_up();
  end

  task automatic start_op(input int m, input int r, input bit neg, input int cnt, input int v);
    @(posedge clk); #1;
    start = 1'b1; mode = 2'(m); radix = 5'(r); neg_lead = neg;
    frac_digits = CW'(cnt); value_in = W'(v);
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    do begin @(negedge clk); t++; end while (!done && t < 2000);
  endtask

  function automatic int horner_ref(input int r, input bit neg);
    int acc = 0;
    bit first = 1'b1;
    for (int i = 0; i < hn; i++) begin
      if (hdig[i] < r) begin
        if (first && neg) acc = (-hdig[i]) & 16'hFFFF;
        else              acc = (acc * r + hdig[i]) & 16'hFFFF;
        first = 1'b0;
        if (hlast[i]) break;
      end
    end
    return acc;
  endfunction

  task automatic run_horn(input int r, input bit neg, input string req, input bit exp_err);
    int expv = horner_ref(r, neg);
    start_op(0, r, neg, 0, 0);
    for (int i = 0; i < hn; i++) begin
      bit acc;
      in_valid = 1'b1; in_digit = DW'(hdig[i]); in_last = hlast[i];
      do begin @(negedge clk); acc = in_ready; @(posedge clk); end while (!acc);
      #1;
    end
    in_valid = 1'b0; in_last = 1'b0;
    wait_done();
    chk(done == 1'b1, req, int'(done), 1);
    chk(int'(result) == expv, req, int'(result), expv);
    chk(err == exp_err, "R3", int'(err), int'(exp_err));
  endtask

  task automatic run_int(input int r, input int v, input int stall, input string req);
    int x = v;
    cur_req = req;
    do begin expq.push_back(x % r); x = x / r; end while (x != 0);
    stall_mode = stall;
    start_op(1, r, 1'b0, 0, v);
    wait_done();
    chk(expq.size() == 0, req, expq.size(), 0);
    chk(err == 1'b0 && busy == 1'b0, "R9", int'(err), 0);
    expq.delete();
  endtask

  task automatic run_frac(input int r, input int v, input int cnt, input int stall);
    int f = v;
    cur_req = "R6";
    for (int i = 0; i < cnt; i++) begin
      int p = f * r;
      expq.push_back(p >> 16);
      f = p & 16'hFFFF;
    end
    stall_mode = stall;
    start_op(2, r, 1'b0, cnt, v);
    wait_done();
    chk(expq.size() == 0, "R6", expq.size(), 0);
    chk(done == 1'b1, "R6", int'(done), 1);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset state
    chk(!busy && !done && !err && !out_valid && !in_ready, "R9",
        int'({busy, done, err, out_valid, in_ready}), 0);
    rst_n = 1'b1;

    // R1: 10110101 radix 2 -> 181
    hn = 8;
    foreach (hdig[i]) begin hdig[i] = 0; hlast[i] = 0; end
    {hdig[0],hdig[1],hdig[2],hdig[3],hdig[4],hdig[5],hdig[6],hdig[7]} = {1,0,1,1,0,1,0,1};
    hlast[7] = 1;
    run_horn(2, 1'b0, "R1", 1'b0);
    chk(result == 16'd181, "R1", int'(result), 181);
    // R2: signed -> -75
    run_horn(2, 1'b1, "R2", 1'b0);
    chk(result == 16'hFFB5, "R2", int'(result), 16'hFFB5);
    // R1: radix 10 digits 1..5
    hn = 5; hlast[7] = 0;
    for (int i = 0; i < 5; i++) hdig[i] = i + 1;
    hlast[4] = 1;
    run_horn(10, 1'b0, "R1", 1'b0);
    chk(result == 16'd12345, "R1", int'(result), 12345);
    // R3: bad digit mid-stream and bad digit carrying last (radix 3)
    hn = 4; hlast[4] = 0;
    hdig[0] = 2; hdig[1] = 7; hdig[2] = 5; hdig[3] = 1;
    hlast[0] = 0; hlast[1] = 0; hlast[2] = 1; hlast[3] = 1;
    run_horn(3, 1'b0, "R3", 1'b1);
    chk(result == 16'd7, "R3", int'(result), 7);
    // R2 with radix 10: leading digit negative, -3*10+4 = -26
    hn = 2; hdig[0] = 3; hdig[1] = 4; hlast[0] = 0; hlast[1] = 1;
    run_horn(10, 1'b1, "R2", 1'b0);

    // R4: integer output
    run_int(3, 19, 1, "R4");
    run_int(10, 65535, 1, "R4");
    run_int(16, 65535, 1, "R4");
    run_int(2, 16'hA5, 0, "R4");
    run_int(7, 40000, 1, "R4");
    // R5: zero operand
    run_int(10, 0, 1, "R5");
    run_int(8, 0, 0, "R5");

    // R6: fraction output
    run_frac(2, 47186, 4, 1);
    run_frac(10, 47186, 6, 1);
    run_frac(10, 24576, 3, 0);
    run_frac(16, 16'h1234, 4, 1);
    run_frac(3, 21845, 12, 1);
    // R6: zero count
    start_op(2, 10, 1'b0, 0, 12345);
    @(negedge clk);
    chk(done && !busy && !out_valid, "R6", int'({done, busy, out_valid}), 4);

    // R8: bad radix and bad mode
    start_op(1, 1, 1'b0, 0, 5);
    @(negedge clk);
    chk(err && done && !busy && !out_valid, "R8", int'({err, done, busy}), 6);
    start_op(1, 17, 1'b0, 0, 5);
    @(negedge clk);
    chk(err && done && !busy, "R8", int'({err, done, busy}), 6);
    start_op(3, 10, 1'b0, 4, 5);
    @(negedge clk);
    chk(err && done && !busy && !in_ready, "R8", int'({err, done, busy}), 6);

    // R9: start while busy ignored
    cur_req = "R9";
    expq.push_back(1); expq.push_back(0); expq.push_back(2);
    stall_mode = 2;
    start_op(1, 3, 1'b0, 0, 19);
    repeat (30) @(posedge clk);
    start_op(0, 10, 1'b0, 0, 999);
    @(negedge clk);
    chk(busy && !in_ready && !done, "R9", int'({busy, in_ready, done}), 4);
    stall_mode = 1;
    wait_done();
    chk(expq.size() == 0, "R9", expq.size(), 0);
    expq.delete();

    repeat (5) @(posedge clk);
    wrap_up();
  end
endmodule